// File: doc/BRIEF.md
# Four-Channel PS/2 Host Shift Engine

This block is a PS/2 host controller in which four PS/2 ports share one serial shift engine. Each port has an open-drain clock line and an open-drain data line. The block drives the pull-low enables for both lines and reads the pin levels back. A small byte-wide register file sets up the engine and lets software watch it. While the engine is idle, it watches every port whose clock software has released. The first port that starts a frame owns the engine until software resets it.

In receive mode, the engine shifts in one 11-bit device frame: a low start bit, eight data bits sent least significant first, an odd parity bit and a high stop bit. It stores the byte and flags parity and framing faults.

In transmit mode, software first loads a byte. It then pulls the chosen port's data line low and releases that port's clock, which forms a request-to-send. The engine shifts the byte, the parity bit and a released stop bit out on the device's clock edges, then samples the device's acknowledge bit.

The device clock is passed through a two-flop synchronizer, and every bit is taken on its synchronized falling edge. The start and end flags stay set after a frame. They clear only when software pulls all four port clocks low at once, or clears the engine enable. This same action is the recovery path if a device stops clocking partway through a frame.

Top module: `ps2_quad_host`

## Requirements
- R1: After reset, the control register (address 0), the status register (address 1) and the interrupt-enable register (address 4) read 0, and the line register (address 3) reads 0x47. All four clock pull-low outputs are 1, all four data pull-low outputs are 0, and irq is 0.
- R2: In the line register, bits 3, 4, 5 and 7 release the clocks of ports 0 to 3, and bits 0, 1, 2 and 6 release their data lines (1 releases a line, 0 pulls it low). Each pull-low output is the inverse of its bit, except while the engine itself is driving a port's data line.
- R3: When the engine is idle with the control enable bit (bit 0) set and the transmit bit (bit 1) clear, a synchronized falling clock edge on a released port whose data line is low sets the start flag (status bit 0). It also sets the port field (status bits 6:4) to 1, 2, 4 or 5 for port 0, 1, 2 or 3. When several ports start in the same cycle, the lowest-numbered port wins.
- R4: A received frame takes eight data bits, least significant bit first, then parity, then stop. On the stop edge, the end flag (status bit 1) is set and the byte becomes readable at address 2.
- R5: On receive, status bit 2 is set when the data bits and the parity bit together hold an even number of ones. Status bit 3 is set when the stop bit is low. The byte is stored in both cases.
- R6: The status flags and the port field stay unchanged through later clock edges on any port. They return to 0 one cycle after all four clock bits are 0, or after the control enable bit is 0.
- R7: With the transmit bit set, the engine starts on the first falling edge of a released port whose data bit is 0. After that edge and the next seven, the engine drives data bits 0 to 7 in order. After the ninth edge it drives odd parity, and after the tenth it releases the line. On the eleventh edge it sets the end flag, and it sets status bit 3 if the data line is high (no acknowledge).
- R8: irq is high when the start flag and interrupt-enable bit 0 are both set, or when the end flag and interrupt-enable bit 1 are both set. Only bits 1:0 of the interrupt-enable register are kept, and the other bits read 0.
- R9: If software writes address 2 in the same cycle that the engine stores a received byte, the received byte is kept. A write in any later cycle replaces it.
- R10: Once a frame has started, clock and data activity on the other ports does not change the stored byte or the port field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| ps2_clk_i | input | 4 | Clock pin level per port |
| ps2_dat_i | input | 4 | Data pin level per port |
| ps2_clk_low | output | 4 | Pull clock line low, per port |
| ps2_dat_low | output | 4 | Pull data line low, per port |
| irq | output | 1 | Interrupt request |

## Verification
Two sources can load the data register in the same cycle: a software write, and the engine storing a received byte on the stop edge. The stop edge reaches the engine exactly three clock cycles after the pin falls. The bench sweeps a software write across cycle offsets 0 to 5 from that pin transition, one frame per offset. It expects the received byte when the write lands on or before the storing edge, and the written value when the write lands afterwards.

// File: rtl/ps2q_pkg.sv
package ps2q_pkg;

  localparam int unsigned NCH = 4;

  // line register after reset: data lines released, clocks pulled low
  localparam logic [7:0] LINE_RST = 8'h47;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX, ST_DONE} eng_st_e;

  function automatic int unsigned clk_pos(input int unsigned ch);
    case (ch)
      0:       return 3;
      1:       return 4;
      2:       return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int unsigned dat_pos(input int unsigned ch);
    case (ch)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 6;
    endcase
  endfunction

  // sparse port code reported in the status register
  function automatic logic [2:0] ch_code(input logic [1:0] ch);
    case (ch)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/ps2q_sync.sv
module ps2q_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] clk_i,
  input  logic [W-1:0] dat_i,
  output logic [W-1:0] clk_fall,
  output logic [W-1:0] dat_s
);

  for (genvar i = 0; i < W; i++) begin : g_lane
    logic c1_q, c2_q, c3_q, d1_q, d2_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c1_q <= 1'b1;
        c2_q <= 1'b1;
        c3_q <= 1'b1;
        d1_q <= 1'b1;
        d2_q <= 1'b1;
      end else begin
        c1_q <= clk_i[i];
        c2_q <= c1_q;
        c3_q <= c2_q;
        d1_q <= dat_i[i];
        d2_q <= d1_q;
      end
    end

    assign clk_fall[i] = c3_q & ~c2_q;
    assign dat_s[i]    = d2_q;
  end

endmodule

// File: rtl/ps2q_engine.sv
module ps2q_engine
  import ps2q_pkg::*;
#(
  parameter  int unsigned NCH = 4,
  parameter  int unsigned DW  = 8,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           xmt,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] dat_rel,
  input  logic [NCH-1:0] fall,
  input  logic [NCH-1:0] dat_s,
  input  logic [DW-1:0]  tx_byte,
  output logic           sot,
  output logic           eot,
  output logic           perr,
  output logic           ferr,
  output logic [CHW-1:0] act_ch,
  output logic           cap,
  output logic [DW-1:0]  rx_byte,
  output logic [NCH-1:0] tx_own,
  output logic           tx_lvl
);

  localparam int unsigned CW = $clog2(DW + 3);
  localparam int unsigned IW = $clog2(DW);
  localparam logic [CW-1:0] C_PAR  = CW'(DW);
  localparam logic [CW-1:0] C_STOP = CW'(DW + 1);

  eng_st_e        st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [DW-1:0]  sh_q, sh_d;
  logic           par_q, par_d;
  logic [CHW-1:0] ch_q, ch_d, sel;
  logic           sot_q, sot_d, eot_q, eot_d;
  logic           perr_q, perr_d, ferr_q, ferr_d;
  logic           lvl_q, lvl_d;
  logic [NCH-1:0] cand;
  logic           fall_a, dat_a;

  // a start needs a low data line: the pin in receive, the request in transmit
  always_comb begin
    cand = fall & ch_en & (xmt ? ~dat_rel : ~dat_s);
    sel  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i]) sel = CHW'(i);
    end
  end

  assign fall_a = fall[ch_q];
  assign dat_a  = dat_s[ch_q];

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    par_d  = par_q;
    ch_d   = ch_q;
    sot_d  = sot_q;
    eot_d  = eot_q;
    perr_d = perr_q;
    ferr_d = ferr_q;
    lvl_d  = lvl_q;
    cap    = 1'b0;
    if (clr) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      ch_d   = '0;
      sot_d  = 1'b0;
      eot_d  = 1'b0;
      perr_d = 1'b0;
      ferr_d = 1'b0;
      lvl_d  = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (|cand) begin
          sot_d = 1'b1;
          ch_d  = sel;
          if (xmt) begin
            st_d  = ST_TX;
            sh_d  = tx_byte;
            lvl_d = tx_byte[0];
            cnt_d = CW'(1);
          end else begin
            st_d  = ST_RX;
            cnt_d = '0;
          end
        end
        ST_RX: if (fall_a) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q < C_PAR) begin
            sh_d = {dat_a, sh_q[DW-1:1]};
          end else if (cnt_q == C_PAR) begin
            par_d = dat_a;
          end else begin
            eot_d  = 1'b1;
            perr_d = ~(^sh_q ^ par_q);
            ferr_d = ~dat_a;
            cap    = 1'b1;
            st_d   = ST_DONE;
          end
        end
        ST_TX: if (fall_a) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q < C_PAR) begin
            lvl_d = sh_q[cnt_q[IW-1:0]];
          end else if (cnt_q == C_PAR) begin
            lvl_d = ~^sh_q;
          end else if (cnt_q == C_STOP) begin
            lvl_d = 1'b1;
          end else begin
            eot_d  = 1'b1;
            ferr_d = dat_a;
            lvl_d  = 1'b1;
            st_d   = ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      ch_q   <= '0;
      sot_q  <= 1'b0;
      eot_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      lvl_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      ch_q   <= ch_d;
      sot_q  <= sot_d;
      eot_q  <= eot_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
      lvl_q  <= lvl_d;
    end
  end

  always_comb begin
    tx_own = '0;
    if (st_q == ST_TX) tx_own[ch_q] = 1'b1;
  end

  assign sot     = sot_q;
  assign eot     = eot_q;
  assign perr    = perr_q;
  assign ferr    = ferr_q;
  assign act_ch  = ch_q;
  assign rx_byte = sh_q;
  assign tx_lvl  = lvl_q;

endmodule

// File: rtl/ps2_quad_host.sv
module ps2_quad_host
  import ps2q_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [NCH-1:0] ps2_clk_i,
  input  logic [NCH-1:0] ps2_dat_i,
  output logic [NCH-1:0] ps2_clk_low,
  output logic [NCH-1:0] ps2_dat_low,
  output logic           irq
);

  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_DATA = AW'(2);
  localparam logic [AW-1:0] A_LINE = AW'(3);
  localparam logic [AW-1:0] A_IEN  = AW'(4);
  localparam int unsigned   CHW    = $clog2(NCH);

  logic [1:0]     ctrl_q, ctrl_d, ie_q, ie_d;
  logic [DW-1:0]  line_q, line_d, data_q, data_d;
  logic [NCH-1:0] clk_bits, dat_bits, fall, dat_s, tx_own;
  logic           eng_clr, e_sot, e_eot, e_perr, e_ferr, cap, tx_lvl;
  logic [CHW-1:0] act_ch;
  logic [2:0]     act_code;
  logic [DW-1:0]  rx_byte;
  logic [7:0]     stat;

  for (genvar i = 0; i < NCH; i++) begin : g_map
    assign clk_bits[i] = line_q[clk_pos(i)];
    assign dat_bits[i] = line_q[dat_pos(i)];
  end

  ps2q_sync #(.W(NCH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_i    (ps2_clk_i),
    .dat_i    (ps2_dat_i),
    .clk_fall (fall),
    .dat_s    (dat_s)
  );

  assign eng_clr = ~ctrl_q[0] | ~|clk_bits;

  ps2q_engine #(.NCH(NCH), .DW(DW)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (eng_clr),
    .xmt     (ctrl_q[1]),
    .ch_en   (clk_bits),
    .dat_rel (dat_bits),
    .fall    (fall),
    .dat_s   (dat_s),
    .tx_byte (data_q),
    .sot     (e_sot),
    .eot     (e_eot),
    .perr    (e_perr),
    .ferr    (e_ferr),
    .act_ch  (act_ch),
    .cap     (cap),
    .rx_byte (rx_byte),
    .tx_own  (tx_own),
    .tx_lvl  (tx_lvl)
  );

  // register writes; a captured byte takes priority over software
  always_comb begin
    ctrl_d = ctrl_q;
    ie_d   = ie_q;
    line_d = line_q;
    data_d = data_q;
    if (reg_wr) begin
      case (reg_addr)
        A_CTRL:  ctrl_d = reg_wdata[1:0];
        A_DATA:  data_d = reg_wdata;
        A_LINE:  line_d = reg_wdata;
        A_IEN:   ie_d   = reg_wdata[1:0];
        default: ;
      endcase
    end
    if (cap) data_d = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ie_q   <= '0;
      line_q <= DW'(LINE_RST);
      data_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ie_q   <= ie_d;
      line_q <= line_d;
      data_q <= data_d;
    end
  end

  assign act_code = e_sot ? ch_code(act_ch) : 3'd0;
  assign stat     = {1'b0, act_code, e_ferr, e_perr, e_eot, e_sot};

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DW'(ctrl_q);
      A_STAT:  reg_rdata = DW'(stat);
      A_DATA:  reg_rdata = data_q;
      A_LINE:  reg_rdata = line_q;
      A_IEN:   reg_rdata = DW'(ie_q);
      default: reg_rdata = '0;
    endcase
  end

  assign ps2_clk_low = ~clk_bits;
  assign ps2_dat_low = (~dat_bits & ~tx_own) | (tx_own & {NCH{~tx_lvl}});
  assign irq         = (e_sot & ie_q[0]) | (e_eot & ie_q[1]);

endmodule

// File: rtl/ps2q_chk.sv
module ps2q_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] clk_bits,
  input logic       en,
  input logic       sot,
  input logic       eot,
  input logic [2:0] code,
  input logic [1:0] ie,
  input logic       irq,
  input logic [3:0] tx_own
);

  a_r6_clear_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_bits == 4'd0) || !en) |=> (!sot && !eot));

  a_r6_start_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sot && (clk_bits != 4'd0) && en) |=> sot);

  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    sot |-> (code == 3'd1 || code == 3'd2 || code == 3'd4 || code == 3'd5));

  a_r4_end_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> sot);

  a_r8_irq_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (eot && ie[1]) |-> irq);

  a_r7_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_own));

endmodule

bind ps2_quad_host ps2q_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_bits (clk_bits),
  .en       (ctrl_q[0]),
  .sot      (e_sot),
  .eot      (e_eot),
  .code     (act_code),
  .ie       (ie_q),
  .irq      (irq),
  .tx_own   (tx_own)
);

// File: tb/ps2_quad_host_bench.sv
module ps2_quad_host_bench;

  localparam int H = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr;
  logic [2:0] addr;
  logic [7:0] wdata;
  wire  [7:0] rdata;
  logic [3:0] dev_clk, dev_dat;
  wire  [3:0] cdl, ddl, pin_c, pin_d;
  wire        irq;
  int         checks = 0;
  int         errors = 0;
  int unsigned seed_dummy;

  always #5 clk = ~clk;

  assign pin_c = dev_clk & ~cdl;
  assign pin_d = dev_dat & ~ddl;

  ps2_quad_host u_ps2_quad_host (
    .clk (clk), .rst_n (rst_n), .reg_wr (wr), .reg_addr (addr),
    .reg_wdata (wdata), .reg_rdata (rdata), .ps2_clk_i (pin_c),
    .ps2_dat_i (pin_d), .ps2_clk_low (cdl), .ps2_dat_low (ddl), .irq (irq)
  );

  function automatic int cpos(int ch);
    return (ch == 3) ? 7 : 3 + ch;
  endfunction
  function automatic int dpos(int ch);
    return (ch == 3) ? 6 : ch;
  endfunction
  function automatic logic [2:0] bcode(int ch);
    return (ch >= 2) ? 3'(ch + 2) : 3'(ch + 1);
  endfunction
  function automatic logic [7:0] st_exp(int ch, bit pe, bit fe);
    return {1'b0, bcode(ch), fe, pe, 2'b11};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wrr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic eng_reset(input logic [7:0] rel);
    wrr(3'd3, 8'h47);
    repeat (6) @(negedge clk);
    wrr(3'd3, rel);
    repeat (6) @(negedge clk);
  endtask

  // device-to-host frame; race >= 0 writes the data register at that
  // offset (in cycles) after the stop-bit clock falls
  task automatic dev_send(int ch, logic [7:0] b, bit badp, bit bads,
                          int race, logic [7:0] rw);
    logic [10:0] fr;
    fr = {~bads, (~^b) ^ badp, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      dev_dat[ch] = fr[i];
      repeat (H) @(negedge clk);
      dev_clk[ch] = 1'b0;
      for (int j = 0; j < H; j++) begin
        if (i == 10 && race >= 0) begin
          wr = (j == race); addr = 3'd2; wdata = rw;
        end
        @(negedge clk);
      end
      wr = 1'b0;
      dev_clk[ch] = 1'b1;
    end
    @(negedge clk);
    dev_dat[ch] = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  // host-to-device frame seen by the device model
  task automatic dev_recv(int ch, bit ack, output logic [10:0] got);
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk);
      if (k == 11 && ack) dev_dat[ch] = 1'b0;
      repeat (H) @(negedge clk);
      dev_clk[ch] = 1'b0;
      repeat (H) @(negedge clk);
      got[k-1] = pin_d[ch];
      dev_clk[ch] = 1'b1;
    end
    repeat (2) @(negedge clk);
    dev_dat[ch] = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic tx_run(int ch, logic [7:0] b, bit ack);
    logic [10:0] got;
    logic [7:0]  st;
    wrr(3'd3, 8'h47);
    repeat (6) @(negedge clk);
    wrr(3'd2, b);
    wrr(3'd3, (8'h47 & ~(8'd1 << dpos(ch))) | (8'd1 << cpos(ch)));
    repeat (6) @(negedge clk);
    chk("R7 request holds data low", int'(pin_d[ch]), 0);
    dev_recv(ch, ack, got);
    chk("R7 data bits", int'(got[7:0]), int'(b));
    chk("R7 odd parity", int'(got[8]), int'(~^b));
    chk("R7 stop released", int'(got[9]), 1);
    rd(3'd1, st);
    chk("R7 status", int'(st), int'(st_exp(ch, 1'b0, ~ack)));
  endtask

  task automatic rx_run(int ch, logic [7:0] b, bit pe, bit fe);
    logic [7:0] st, d;
    eng_reset(8'hFF);
    dev_send(ch, b, pe, fe, -1, 8'h00);
    rd(3'd1, st);
    chk("R4 R5 status", int'(st), int'(st_exp(ch, pe, fe)));
    rd(3'd2, d);
    chk("R4 byte", int'(d), int'(b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    seed_dummy = $urandom(32'd1357);
    rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    dev_clk = 4'hF; dev_dat = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd3, v); chk("R1 line reg", int'(v), 8'h47);
    rd(3'd1, v); chk("R1 status", int'(v), 0);
    rd(3'd0, v); chk("R1 control", int'(v), 0);
    rd(3'd4, v); chk("R1 irq enable", int'(v), 0);
    chk("R1 clock pull-low", int'(cdl), 4'hF);
    chk("R1 data pull-low", int'(ddl), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 bit mapping
    wrr(3'd3, 8'h4F);
    #1 chk("R2 port0 clock bit 3", int'(cdl), 4'b1110);
    wrr(3'd3, 8'h07);
    #1 chk("R2 port3 data bit 6", int'(ddl), 4'b1000);
    wrr(3'd3, 8'h47 | 8'h80);
    #1 chk("R2 port3 clock bit 7", int'(cdl), 4'b0111);
    // R8 only low two enable bits kept
    wrr(3'd4, 8'hFF);
    rd(3'd4, v); chk("R8 enable width", int'(v), 3);
    wrr(3'd4, 8'h00);

    // R3 R4 directed receive
    wrr(3'd0, 8'h01);
    rx_run(2, 8'hA5, 1'b0, 1'b0);
    wrr(3'd4, 8'h02);
    #1 chk("R8 irq on end", int'(irq), 1);
    wrr(3'd4, 8'h00);
    #1 chk("R8 irq masked", int'(irq), 0);
    wrr(3'd4, 8'h01);
    #1 chk("R8 irq on start", int'(irq), 1);
    wrr(3'd4, 8'h00);

    // R6 later frame ignored, then cleared by reset
    dev_send(0, 8'h3C, 1'b0, 1'b0, -1, 8'h00);
    rd(3'd2, v); chk("R6 byte kept after end", int'(v), 8'hA5);
    rd(3'd1, v); chk("R6 status kept", int'(v), int'(st_exp(2, 0, 0)));
    eng_reset(8'hFF);
    rd(3'd1, v); chk("R6 cleared by all clocks low", int'(v), 0);
    wrr(3'd0, 8'h00);
    repeat (2) @(negedge clk);
    wrr(3'd0, 8'h01);
    rd(3'd1, v); chk("R6 cleared by enable", int'(v), 0);

    // R5 error cases
    rx_run(3, 8'h81, 1'b1, 1'b0);
    rx_run(1, 8'h00, 1'b0, 1'b1);
    rx_run(0, 8'hFF, 1'b1, 1'b1);

    // R3 simultaneous start, lowest port wins
    eng_reset(8'hFF);
    fork
      dev_send(1, 8'h11, 1'b0, 1'b0, -1, 8'h00);
      dev_send(2, 8'h22, 1'b0, 1'b0, -1, 8'h00);
    join
    rd(3'd1, v); chk("R3 priority status", int'(v), int'(st_exp(1, 0, 0)));
    rd(3'd2, v); chk("R3 priority byte", int'(v), 8'h11);

    // R10 activity on another port during a frame
    eng_reset(8'hFF);
    fork
      dev_send(1, 8'h5A, 1'b0, 1'b0, -1, 8'h00);
      begin
        repeat (H + 10) @(negedge clk);
        dev_dat[3] = 1'b0;
        for (int n = 0; n < 20; n++) begin
          dev_clk[3] = 1'b0; repeat (9) @(negedge clk);
          dev_clk[3] = 1'b1; repeat (9) @(negedge clk);
        end
        dev_dat[3] = 1'b1;
      end
    join
    rd(3'd1, v); chk("R10 port field", int'(v), int'(st_exp(1, 0, 0)));
    rd(3'd2, v); chk("R10 byte", int'(v), 8'h5A);

    // R9 software write against byte capture
    for (int k = 0; k < 6; k++) begin
      eng_reset(8'hFF);
      dev_send(0, 8'hC3, 1'b0, 1'b0, k, 8'(8'h70 + k));
      rd(3'd2, v);
      chk("R9 capture versus write", int'(v), (k <= 2) ? 8'hC3 : 8'h70 + k);
    end

    // random receive
    for (int n = 0; n < 12; n++) begin
      int ch, e;
      logic [7:0] b;
      ch = int'($urandom % 4);
      b  = 8'($urandom);
      e  = int'($urandom % 4);
      rx_run(ch, b, e == 1, e == 2);
    end

    // R7 transmit: directed, no-acknowledge, random
    wrr(3'd0, 8'h03);
    tx_run(0, 8'h96, 1'b1);
    tx_run(3, 8'h01, 1'b0);
    for (int n = 0; n < 6; n++) begin
      int ch;
      logic [7:0] b;
      ch = int'($urandom % 4);
      b  = 8'($urandom);
      tx_run(ch, b, 1'b1);
    end

    // back to receive after transmit
    wrr(3'd3, 8'h47);
    wrr(3'd0, 8'h01);
    rx_run(2, 8'h6E, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule